// File: doc/BRIEF.md
# I2C Serial Memory Read Controller

This block is an I2C target that fronts a 512-byte general-purpose storage array and two one-byte special registers, a control byte and a fault byte. It samples SCL and SDA with the system clock and detects START and STOP conditions. It decodes the addressing byte that follows a START. It answers on SDA through an open-drain enable, so a high level on `sda_oe_o` pulls the line low.

A single 9-bit address counter serves the array for both reads and writes. A write transfer loads the counter from the addressing byte's address bit and the word byte that follows it. If the host ends that transfer with STOP, only the counter changes. Reads start from the counter and step through the array while the host keeps acknowledging, wrapping from the top address to zero. The two special registers are reached through a separate device-type value together with a fixed word byte of all ones.

Top module: `i2c_mem_slave`

## Requirements
- R1: An addressing byte is acknowledged (SDA held low during the ninth SCL pulse) only when bits 7..5 are 101 and bits 3..2 are 00. Any other byte is not acknowledged, and the block ignores all bus activity, including later bytes, until the next START.
- R2: After addressing byte 1010_00 A8 0 and a word byte W, each data byte is acknowledged and stored at address {A8,W}. The counter then advances by one, wrapping from 0x1FF to 0x000.
- R3: An addressing byte and word byte followed directly by STOP load the counter with {A8,W} and store nothing. The next current-address read returns the byte at {A8,W}.
- R4: A read with addressing byte 1010_00 x 1 returns the byte at the counter, and the x bit is ignored. Every transmitted array byte advances the counter by one, so the next current-address read continues at the following address.
- R5: While the host acknowledges each byte, the block sends the bytes at n, n+1, ... in order, and continues from 0x000 after 0x1FF.
- R6: After a host non-acknowledge, SDA stays released for every further SCL pulse until the next START.
- R7: Addressing bits 7..4 = 1011 select a special register: bit 1 = 1 selects the control byte and bit 1 = 0 selects the fault byte. For a write, the word byte must be 0xFF or it is not acknowledged. Data bytes written overwrite the selected register. Every byte of a read returns the selected register, and the array counter is left unchanged.
- R8: Synchronous reset releases SDA and sets both the control byte (CTRL_INIT) and the fault byte (FAULT_INIT) to 0x00.
- R9: SDA is pulled low only starting from a clock where SCL is low. A START or STOP releases SDA on the next clock and restarts byte framing, even in the middle of a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level (wired-AND bus) |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The bench fills the whole array in one write burst, which makes the counter wrap. It then reads the array back in several ways: directed address-set reads across the 0x1FF boundary, current-address reads that must continue where the last transfer stopped, and random mixes of address-set, burst-write and sequential-read transfers. Each pattern separates a different counter source: the word-byte load, the per-byte advance and the wraparound. Directed cases cover malformed addressing bytes, a wrong register word byte, bytes clocked after a non-acknowledge and a START inside a byte. Each shows whether the block correctly stays silent or restarts framing.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam int WORD_W  = 8;
    localparam int ADDR_W  = WORD_W + 1;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int NREG    = 2;
    localparam int REG_CTRL = 1;

    localparam logic [2:0]        DEV_TYPE = 3'b101;
    localparam logic [WORD_W-1:0] REG_WORD = '1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACKWAIT,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_e;

    typedef enum logic [1:0] {
        BY_DEV,
        BY_WORD,
        BY_DATA
    } byte_e;

    typedef struct packed {
        logic reg_space;
        logic sel;
        logic rd;
    } dev_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_ok(input logic [WORD_W-1:0] b);
        return (b[7:5] == DEV_TYPE) && (b[3:2] == 2'b00);
    endfunction

    function automatic dev_t dev_fields(input logic [WORD_W-1:0] b);
        dev_t d;
        d.reg_space = b[4];
        d.sel       = b[1];
        d.rd        = b[0];
        return d;
    endfunction

endpackage

// File: rtl/i2c_mem_line_mon.sv
module i2c_mem_line_mon
    import i2c_mem_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.scl_rise = !scl_q && scl_i;
        ev.scl_fall = scl_q && !scl_i;
        ev.start    = scl_q && scl_i && sda_q && !sda_i;
        ev.stop     = scl_q && scl_i && !sda_q && sda_i;
    end

endmodule

// File: rtl/i2c_mem_store.sv
module i2c_mem_store
    import i2c_mem_pkg::*;
#(
    parameter logic [WORD_W-1:0] CTRL_INIT  = '0,
    parameter logic [WORD_W-1:0] FAULT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              sp_reg,
    input  logic              sp_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem  [DEPTH];
    logic [WORD_W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && !sp_reg) begin
            mem[addr] <= wdata;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [WORD_W-1:0] INIT = (g == REG_CTRL) ? CTRL_INIT : FAULT_INIT;
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= INIT;
            end else if (we && sp_reg && (int'(sp_sel) == g)) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata = sp_reg ? regs[sp_sel] : mem[addr];

endmodule

// File: rtl/i2c_mem_engine.sv
module i2c_mem_engine
    import i2c_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              sda_i,
    input  logic [WORD_W-1:0] rdata,
    output logic              sda_oe,
    output logic              we,
    output logic              sp_reg,
    output logic              sp_sel,
    output logic [ADDR_W-1:0] cnt,
    output logic [WORD_W-1:0] wdata
);

    phase_e            phase;
    byte_e             kind;
    logic [3:0]        bitcnt;
    logic [6:0]        shreg;
    logic [WORD_W-1:0] txsh;
    dev_t              dev;
    logic [WORD_W-1:0] nb;
    logic              byte_ok;

    assign nb = {shreg, sda_i};

    always_comb begin
        unique case (kind)
            BY_DEV:  byte_ok = dev_ok(nb);
            BY_WORD: byte_ok = !dev.reg_space || (nb == REG_WORD);
            default: byte_ok = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            kind   <= BY_DEV;
            bitcnt <= '0;
            shreg  <= '0;
            txsh   <= '0;
            dev    <= '0;
            cnt    <= '0;
            sda_oe <= 1'b0;
            we     <= 1'b0;
            wdata  <= '0;
        end else begin
            we <= 1'b0;
            if (we && !dev.reg_space) begin
                cnt <= cnt + 1'b1;
            end
            if (ev.start) begin
                phase  <= PH_RX;
                kind   <= BY_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (phase)
                    PH_RX: if (ev.scl_rise) begin
                        shreg  <= nb[6:0];
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 4'd7) begin
                            phase <= byte_ok ? PH_ACKWAIT : PH_IDLE;
                            unique case (kind)
                                BY_DEV:  dev <= dev_fields(nb);
                                BY_WORD: if (!dev.reg_space) cnt <= {dev.sel, nb};
                                default: begin
                                    we    <= 1'b1;
                                    wdata <= nb;
                                end
                            endcase
                        end
                    end
                    PH_ACKWAIT: if (ev.scl_fall) begin
                        sda_oe <= 1'b1;
                        phase  <= PH_ACK;
                    end
                    PH_ACK: if (ev.scl_fall) begin
                        if (kind == BY_DEV && dev.rd) begin
                            txsh   <= rdata;
                            sda_oe <= ~rdata[7];
                            bitcnt <= 4'd1;
                            phase  <= PH_TX;
                            if (!dev.reg_space) cnt <= cnt + 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            phase  <= PH_RX;
                            kind   <= (kind == BY_DEV) ? BY_WORD : BY_DATA;
                        end
                    end
                    PH_TX: if (ev.scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            phase  <= PH_MACK;
                        end else begin
                            sda_oe <= ~txsh[6];
                            txsh   <= {txsh[6:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    PH_MACK: begin
                        if (ev.scl_rise && sda_i) begin
                            phase <= PH_IDLE;
                        end else if (ev.scl_fall) begin
                            txsh   <= rdata;
                            sda_oe <= ~rdata[7];
                            bitcnt <= 4'd1;
                            phase  <= PH_TX;
                            if (!dev.reg_space) cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sp_reg = dev.reg_space;
    assign sp_sel = dev.sel;

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter logic [WORD_W-1:0] CTRL_INIT  = '0,
    parameter logic [WORD_W-1:0] FAULT_INIT = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);

    bus_ev_t           ev;
    logic              wr_en;
    logic              sp_reg;
    logic              sp_sel;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] wr_data;
    logic [WORD_W-1:0] rd_data;

    i2c_mem_line_mon u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_mem_engine u_eng (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .sda_i  (sda_i),
        .rdata  (rd_data),
        .sda_oe (sda_oe_o),
        .we     (wr_en),
        .sp_reg (sp_reg),
        .sp_sel (sp_sel),
        .cnt    (cur_addr),
        .wdata  (wr_data)
    );

    i2c_mem_store #(
        .CTRL_INIT  (CTRL_INIT),
        .FAULT_INIT (FAULT_INIT)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_en),
        .sp_reg (sp_reg),
        .sp_sel (sp_sel),
        .addr   (cur_addr),
        .wdata  (wr_data),
        .rdata  (rd_data)
    );

endmodule

// File: rtl/i2c_mem_chk.sv
module i2c_mem_chk
    import i2c_mem_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_oe,
    input logic              we,
    input logic [ADDR_W-1:0] cnt
);

    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_i;
            sda_d <= sda_i;
        end
    end

    // R9
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_i));

    // R9
    cond_release_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_d && scl_i && (sda_d != sda_i)) |=> !sda_oe);

    // R2
    write_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> !we);

    // R5
    cnt_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt) |-> (($past(scl_i) != $past(scl_d)) || $past(we)));

    // R8
    reset_release_chk: assert property (@(posedge clk)
        rst |=> !sda_oe);

endmodule

bind i2c_mem_slave i2c_mem_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .sda_oe (sda_oe_o),
    .we     (wr_en),
    .cnt    (cur_addr)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb;

    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe_o;
    wire  sda_bus = sda_m & ~sda_oe_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int r9_viol = 0;
    logic oe_prev = 1'b0;

    logic [7:0] mem_m [512];
    logic [7:0] ctrl_m = 8'h00;
    logic [7:0] fault_m = 8'h00;
    logic [8:0] cnt_m = '0;

    always #2 clk = ~clk;

    i2c_mem_slave u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe_o)
    );

    // R9: SDA pull-down may only begin while SCL is low
    always @(negedge clk) begin
        if (!rst && sda_oe_o && !oe_prev && scl_m) r9_viol++;
        oe_prev <= sda_oe_o;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(2);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    hold(Q);
        scl_m = 1'b1; hold(Q);
        scl_m = 1'b0; hold(2);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q / 2);
        b = sda_bus;  hold(Q / 2);
        scl_m = 1'b0; hold(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(x);
        ack = !x;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            b[i] = x;
        end
        put_bit(!mack);
    endtask

    function automatic logic [7:0] exp_next(input logic [7:0] dev);
        logic [7:0] r;
        if (dev[4]) return dev[1] ? ctrl_m : fault_m;
        r = mem_m[cnt_m];
        cnt_m = cnt_m + 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] arr_dev(input logic [8:0] a, input logic rd);
        return {4'b1010, 2'b00, a[8], rd};
    endfunction

    task automatic rd_check(input logic [7:0] dev, input int n, input string tag);
        logic a;
        logic [7:0] b;
        logic [7:0] e;
        bus_start;
        send_byte(dev, a);
        chk(a, {tag, " read addressing ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            e = exp_next(dev);
            chk(b == e, tag, b, e);
        end
        bus_stop;
    endtask

    task automatic wr_array(input logic [8:0] addr, input int n, input string tag);
        logic a;
        logic [7:0] d;
        bus_start;
        send_byte(arr_dev(addr, 1'b0), a);
        chk(a, {tag, " write addressing ack"}, a, 1);
        send_byte(addr[7:0], a);
        chk(a, {tag, " word ack"}, a, 1);
        cnt_m = addr;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, a);
            chk(a, {tag, " data ack"}, a, 1);
            mem_m[cnt_m] = d;
            cnt_m = cnt_m + 1'b1;
        end
        bus_stop;
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        logic a;
        bus_start;
        send_byte({4'b1011, 2'b00, sel, 1'b0}, a);
        chk(a, "R7 register addressing ack", a, 1);
        send_byte(8'hFF, a);
        chk(a, "R7 register word 0xFF ack", a, 1);
        send_byte(d, a);
        chk(a, "R7 register data ack", a, 1);
        bus_stop;
        if (sel) ctrl_m = d; else fault_m = d;
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete actual=%0d expected=%0d", 0, 1);
            summary;
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] b;
        logic [7:0] e;
        int unsigned seed_v;
        seed_v = $urandom(32'd1357);

        hold(5);
        rst = 1'b0;
        hold(3);
        chk(sda_oe_o == 1'b0, "R8 SDA released after reset", sda_oe_o, 0);

        // R8 register reset values, R7 register select on read
        rd_check(8'hB3, 1, "R8 control reset value");
        rd_check(8'hB1, 1, "R8 fault reset value");

        // R2 fill whole array in one burst; counter wraps back to 0x000
        wr_array(9'h000, 512, "R2 fill");
        rd_check(8'hA1, 2, "R2 read after wrapping burst");

        // R2 burst across 0x1FF -> 0x000
        wr_array(9'h1FE, 3, "R2 cross-boundary write");

        // R3 set current address then R5 sequential wrap
        wr_array(9'h1FD, 0, "R3 set address");
        rd_check(8'hA1, 5, "R5 sequential wrap read after R3 set");

        // R4 current read continues, addressing bit 1 ignored on read
        rd_check(8'hA3, 1, "R4 current read ignores A8");
        rd_check(8'hA1, 2, "R4 current read continues");

        // R1 malformed addressing bytes
        bus_start;
        send_byte(8'h90, a);
        chk(!a, "R1 wrong device type not acked", a, 0);
        send_byte(8'hA1, a);
        chk(!a, "R1 ignored until START", a, 0);
        bus_stop;
        bus_start;
        send_byte(8'hA5, a);
        chk(!a, "R1 nonzero bits 3..2 not acked", a, 0);
        bus_stop;
        rd_check(8'hA1, 1, "R1 counter untouched by rejected bytes");

        // R6 after a NACK the block stays silent
        bus_start;
        send_byte(8'hA1, a);
        chk(a, "R6 read addressing ack", a, 1);
        recv_byte(1'b0, b);
        e = exp_next(8'hA1);
        chk(b == e, "R6 byte before NACK", b, e);
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R6 SDA released after NACK", b, 8'hFF);
        bus_stop;
        rd_check(8'hA1, 1, "R6 counter advanced once only");

        // R7 special registers
        wr_reg(1'b1, 8'h3C);
        wr_reg(1'b0, 8'hC5);
        rd_check(8'hB3, 2, "R7 control read repeats");
        rd_check(8'hB1, 2, "R7 fault read repeats");
        bus_start;
        send_byte(8'hB2, a);
        chk(a, "R7 register addressing ack", a, 1);
        send_byte(8'h12, a);
        chk(!a, "R7 word byte not 0xFF rejected", a, 0);
        send_byte(8'h99, a);
        chk(!a, "R7 data after rejected word ignored", a, 0);
        bus_stop;
        rd_check(8'hB3, 1, "R7 control unchanged after rejected word");
        rd_check(8'hA1, 1, "R7 array counter unaffected by register access");

        // R9 START inside a byte restarts framing
        bus_start;
        put_bit(1'b1);
        put_bit(1'b0);
        put_bit(1'b1);
        bus_start;
        send_byte(8'hA1, a);
        chk(a, "R9 addressing ack after mid-byte START", a, 1);
        recv_byte(1'b0, b);
        e = exp_next(8'hA1);
        chk(b == e, "R9 data after mid-byte START", b, e);
        bus_stop;

        // Random mix of address set, burst write and sequential read
        for (int it = 0; it < 25; it++) begin
            int unsigned mode;
            logic [8:0] ad;
            mode = $urandom % 3;
            ad = 9'($urandom);
            if (mode == 0) begin
                wr_array(ad, 0, "R3 random set");
                rd_check(8'hA1, 1 + int'($urandom % 6), "R5 random sequential read");
            end else if (mode == 1) begin
                wr_array(ad, 1 + int'($urandom % 4), "R2 random burst");
                wr_array(ad, 0, "R3 random set");
                rd_check(arr_dev(~ad, 1'b1), 4, "R2 random readback");
            end else begin
                rd_check(8'hA1, 1 + int'($urandom % 5), "R4 random current read");
            end
        end

        chk(r9_viol == 0, "R9 SDA pulled low while SCL high", r9_viol, 0);

        done = 1'b1;
        summary;
        $finish;
    end

endmodule